// File: doc/BRIEF.md
# Frame Transmit Ingress Buffer

This block takes outgoing frames from user logic one 32-bit word at a time and stores them in an internal buffer. The user side uses an active-low handshake. The block accepts a word in every cycle where the user's valid strobe is low, and it tolerates a slow reaction to its own ready signal. A frame ends on the word presented with the end-of-frame strobe low. Only whole frames go to the link side. That side uses an active-high valid/ready pair with a last flag, and a word is handed over in any cycle where both are high.

The user can drop the frame it is writing with a single-cycle abort pulse. The block answers by discarding the partial frame and holding ready high for a fixed window, then lowering it again. The link side can report a cancel or a collision. The block then pulses its own cancel output to the user, and if a frame is partly handed over it skips what is left of that frame. When the link side reports that a frame is finished, it supplies a 2-bit completion code. The block turns that code into a fixed-format 32-bit status word on a separate output.

Top module: `frame_tx_ingress`

## Requirements
- R1: While `rst` is high, `u_ready_n` is high. In the first cycle after reset, `u_ready_n` is low, `l_valid` and `st_valid` are low and `u_cancel_n` is high.
- R2: Words handed to the link come out in the order they were accepted, with identical data. `l_last` is high only on the word that was accepted with `u_last_n` low. While `l_valid` is high and `l_ready` is low (and no cancel arrives), `l_valid`, `l_data` and `l_last` hold their values.
- R3: `l_valid` stays low until the last word of a frame has been accepted. It goes high in the cycle after that word is written.
- R4: `u_ready_n` goes high once 4 or fewer buffer entries are free. Words presented in the 4 cycles after that are still stored and forwarded without loss. With the default depth of 1024, `u_ready_n` rises after exactly 1020 words.
- R5: An abort pulse (`u_abort_n` low for one cycle) while a frame is open removes that frame's stored words. The word presented in the abort cycle and every word presented while `u_ready_n` is high afterwards are dropped. `u_ready_n` is high for exactly 5 cycles after the abort cycle and then returns low.
- R6: An abort pulse while no frame is open has no effect: `u_ready_n` stays low and buffered frames are forwarded intact.
- R7: A cycle with `l_cancel` high is followed by exactly one cycle with `u_cancel_n` low.
- R8: A cancel that arrives after at least one word of a frame (but not its last) has gone to the link discards the rest of that frame, with `l_valid` low while it does so. The next frame is then forwarded normally.
- R9: A cycle with `l_done` high is followed by one cycle with `st_valid` high. In that cycle `st_word` holds 0xEF in bits [7:0], 0 (transmit direction) in bit 26 and the latched `l_code` in bits [25:24], where 00 means no error, 01 a bad or unrecognised frame, 10 a CRC error and 11 is reserved. All other bits are zero.
- R10: When `l_cancel` and `l_done` are high in the same cycle, both the cancel pulse and the status word appear in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, hold at least 4 cycles |
| u_valid_n | input | 1 | User word valid, active low |
| u_ready_n | output | 1 | Block can take words, active low |
| u_last_n | input | 1 | Marks the last word of a frame, active low |
| u_data | input | 32 | User frame word |
| u_abort_n | input | 1 | One-cycle abort of the open frame, active low |
| u_cancel_n | output | 1 | One-cycle notice of a link-side cancel, active low |
| l_valid | output | 1 | Link word valid |
| l_ready | input | 1 | Link accepts the word |
| l_last | output | 1 | Link word ends a frame |
| l_data | output | 32 | Link frame word |
| l_cancel | input | 1 | Link reports cancel or collision |
| l_done | input | 1 | Link reports frame completion |
| l_code | input | 2 | Completion code latched with `l_done` |
| st_valid | output | 1 | Status word valid for one cycle |
| st_word | output | 32 | Completion status word |

## Verification
A link cancel and a completion report can land in the same cycle, which happens on short frames where the cancel comes after the last word. The bench drives `l_cancel` and `l_done` together with code 01. In the very next cycle it expects both `u_cancel_n` low and a status word equal to 0x010000EF. A second overlap is a cancel arriving while the link holds back a mid-frame word. That case is judged by checking that the first word forwarded afterwards is the first word of the following frame.

// File: rtl/frame_tx_ingress.sv
module frame_tx_ingress #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  parameter int SKID  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          u_valid_n,
  output logic          u_ready_n,
  input  logic          u_last_n,
  input  logic [DW-1:0] u_data,
  input  logic          u_abort_n,
  output logic          u_cancel_n,
  output logic          l_valid,
  input  logic          l_ready,
  output logic          l_last,
  output logic [DW-1:0] l_data,
  input  logic          l_cancel,
  input  logic          l_done,
  input  logic [1:0]    l_code,
  output logic          st_valid,
  output logic [31:0]   st_word
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int FLUSH = SKID + 1;
  localparam int FCW   = $clog2(FLUSH + 1);
  localparam logic [7:0] FTYPE = 8'hEF;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DW:0]    mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr, frm_start;
  logic [CW-1:0]  count, frm_len, frames;
  logic [FCW-1:0] flush_cnt;
  logic           in_frame, mid, skip, cancel_q, st_v;
  logic [1:0]     code_q;

  logic          abort_hit, drop, wr_en, wr_last, xfer, rd_en, rd_last_done;
  logic          mid_after, skip_set;
  logic [DW:0]   rd_entry;
  logic [CW-1:0] count_nx;

  assign abort_hit    = !u_abort_n && in_frame && (flush_cnt == '0);
  assign drop         = (flush_cnt != '0) || abort_hit;
  assign wr_last      = !u_last_n;
  assign wr_en        = !u_valid_n && !drop && (count < CW'(DEPTH));
  assign rd_entry     = mem[rd_ptr];
  assign l_valid      = (frames != '0) && !skip;
  assign l_data       = rd_entry[DW-1:0];
  assign l_last       = rd_entry[DW];
  assign xfer         = l_valid && l_ready;
  assign rd_en        = xfer || skip;
  assign rd_last_done = rd_en && rd_entry[DW];
  assign mid_after    = xfer ? !l_last : mid;
  assign skip_set     = l_cancel && mid_after && !skip;
  assign count_nx     = count + CW'(wr_en) - CW'(rd_en) - (abort_hit ? frm_len : '0);

  assign u_ready_n  = rst || (count >= CW'(DEPTH - SKID)) || (flush_cnt != '0);
  assign u_cancel_n = !cancel_q;
  assign st_valid   = st_v;
  assign st_word    = {5'b0, 1'b0, code_q, 16'b0, FTYPE};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= {wr_last, u_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      frm_start <= '0;
      count     <= '0;
      frm_len   <= '0;
      frames    <= '0;
      flush_cnt <= '0;
      in_frame  <= 1'b0;
      mid       <= 1'b0;
      skip      <= 1'b0;
      cancel_q  <= 1'b0;
      st_v      <= 1'b0;
      code_q    <= 2'b00;
    end else begin
      count <= count_nx;
      if (abort_hit) begin
        wr_ptr   <= frm_start;
        in_frame <= 1'b0;
        frm_len  <= '0;
      end else if (wr_en) begin
        wr_ptr   <= nxt(wr_ptr);
        in_frame <= !wr_last;
        frm_len  <= wr_last ? '0 : frm_len + 1'b1;
        if (wr_last) frm_start <= nxt(wr_ptr);
      end
      frames <= frames + CW'(wr_en && wr_last) - CW'(rd_last_done);
      if (abort_hit)            flush_cnt <= FCW'(FLUSH);
      else if (flush_cnt != '0) flush_cnt <= flush_cnt - 1'b1;
      if (rd_en) rd_ptr <= nxt(rd_ptr);
      mid  <= mid_after && !skip_set;
      skip <= skip ? !rd_entry[DW] : skip_set;
      cancel_q <= l_cancel;
      st_v     <= l_done;
      if (l_done) code_q <= l_code;
    end
  end
endmodule

// File: rtl/frame_tx_ingress_chk.sv
module frame_tx_ingress_chk (
  input logic        clk,
  input logic        rst,
  input logic        u_abort_n,
  input logic        u_ready_n,
  input logic        u_cancel_n,
  input logic        l_valid,
  input logic        l_ready,
  input logic        l_last,
  input logic [31:0] l_data,
  input logic        l_cancel,
  input logic        l_done,
  input logic [1:0]  l_code,
  input logic        st_valid,
  input logic [31:0] st_word,
  input logic        in_frame
);
  // R1
  reset_exit_chk: assert property (@(posedge clk) $fell(rst) |-> !l_valid && !st_valid && u_cancel_n);

  // R2
  link_hold_chk: assert property (@(posedge clk) disable iff (rst)
    l_valid && !l_ready && !l_cancel |=> l_valid && $stable(l_data) && $stable(l_last));

  // R5
  abort_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !u_abort_n && in_frame && !u_ready_n |=> u_ready_n && !in_frame);

  // R7
  cancel_pulse_chk: assert property (@(posedge clk) disable iff (rst) l_cancel |=> !u_cancel_n);

  // R7
  cancel_quiet_chk: assert property (@(posedge clk) disable iff (rst) !l_cancel |=> u_cancel_n);

  // R9
  status_word_chk: assert property (@(posedge clk) disable iff (rst)
    l_done |=> st_valid && st_word == {5'b0, 1'b0, $past(l_code), 16'h0000, 8'hEF});

  // R9
  status_quiet_chk: assert property (@(posedge clk) disable iff (rst) !l_done |=> !st_valid);
endmodule

bind frame_tx_ingress frame_tx_ingress_chk chk_i (.*);

// File: tb/frame_tx_ingress_test.sv
`timescale 1ns/1ps
module frame_tx_ingress_test;
  localparam int DEPTH = 1024;
  localparam int SKID  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic u_valid_n = 1'b1, u_last_n = 1'b1, u_abort_n = 1'b1;
  logic [31:0] u_data = '0;
  logic u_ready_n, u_cancel_n, l_valid, l_last, st_valid;
  logic [31:0] l_data, st_word;
  logic l_ready = 1'b0, l_cancel = 1'b0, l_done = 1'b0;
  logic [1:0] l_code = 2'b00;

  int tests = 0, fails = 0;
  logic [32:0] exp_q[$];

  always #10 clk = ~clk;

  frame_tx_ingress #(.DW(32), .DEPTH(DEPTH), .SKID(SKID)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d, input bit last);
    @(negedge clk);
    u_valid_n = 1'b0; u_data = d; u_last_n = !last;
  endtask

  task automatic idle();
    @(negedge clk);
    u_valid_n = 1'b1; u_last_n = 1'b1;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (exp_q.size() > 0 && guard < 5000) begin
      @(negedge clk);
      l_ready = 1'b1;
      guard++;
      if (l_valid) begin
        logic [32:0] e;
        e = exp_q.pop_front();
        chk({l_last, l_data} == e, req, {l_last, l_data}, e);
      end
    end
    chk(exp_q.size() == 0, {req, " all words"}, exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    l_ready = 1'b0;
    chk(!l_valid, {req, " no extra word"}, l_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(u_ready_n, "R1 ready high in reset", u_ready_n, 1);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!u_ready_n && !l_valid && !st_valid && u_cancel_n, "R1 state after reset",
        {u_ready_n, l_valid, st_valid, u_cancel_n}, 4'b0001);
  endtask

  task automatic t_basic();
    push(32'hA000_0000, 0); exp_q.push_back({1'b0, 32'hA000_0000});
    push(32'hA000_0001, 0); exp_q.push_back({1'b0, 32'hA000_0001});
    push(32'hA000_0002, 1); exp_q.push_back({1'b1, 32'hA000_0002});
    chk(!l_valid, "R3 no output before end of frame", l_valid, 0);
    idle();
    chk(l_valid, "R3 output once frame complete", l_valid, 1);
    @(negedge clk);
    chk(l_valid && l_data == 32'hA000_0000, "R2 head held while link stalls", l_data, 32'hA000_0000);
    drain("R2 three-word frame");
    push(32'h5151_5151, 1); exp_q.push_back({1'b1, 32'h5151_5151});
    idle();
    drain("R2 single-word frame");
  endtask

  task automatic t_status();
    @(negedge clk); l_done = 1'b1; l_code = 2'b10;
    @(negedge clk); l_done = 1'b0; l_code = 2'b00;
    chk(st_valid && st_word == 32'h0200_00EF, "R9 CRC status word", st_word, 32'h0200_00EF);
    @(negedge clk);
    chk(!st_valid, "R9 status one cycle", st_valid, 0);
    l_done = 1'b1;
    @(negedge clk); l_done = 1'b0;
    chk(st_valid && st_word == 32'h0000_00EF, "R9 clean status word", st_word, 32'h0000_00EF);
  endtask

  task automatic t_fill();
    int k = 0;
    forever begin
      @(negedge clk);
      if (u_ready_n || k >= DEPTH) break;
      u_valid_n = 1'b0; u_data = 32'h1000_0000 + k; u_last_n = 1'b1;
      exp_q.push_back({1'b0, 32'h1000_0000 + k});
      k++;
    end
    chk(k == DEPTH - SKID, "R4 ready drops with 4 free", k, DEPTH - SKID);
    for (int j = 0; j < SKID; j++) begin
      if (j > 0) @(negedge clk);
      u_valid_n = 1'b0; u_data = 32'h1000_0000 + k + j; u_last_n = !(j == SKID - 1);
      exp_q.push_back({j == SKID - 1, 32'h1000_0000 + k + j});
    end
    idle();
    chk(u_ready_n && l_valid, "R4 full buffer holds frame", {u_ready_n, l_valid}, 2'b11);
    drain("R4 skid words kept");
    chk(!u_ready_n, "R4 ready back after drain", u_ready_n, 0);
  endtask

  task automatic t_abort();
    int highs = 0;
    push(32'hB000_0000, 0);
    push(32'hB000_0001, 0);
    push(32'hB000_0002, 0);
    @(negedge clk);
    u_valid_n = 1'b1; u_abort_n = 1'b0;
    @(negedge clk);
    u_abort_n = 1'b1; u_valid_n = 1'b0; u_data = 32'hDEAD_0001; u_last_n = 1'b1;
    highs += int'(u_ready_n);
    @(negedge clk);
    u_data = 32'hDEAD_0002; u_last_n = 1'b0;
    highs += int'(u_ready_n);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      u_valid_n = 1'b1; u_last_n = 1'b1;
      highs += int'(u_ready_n);
    end
    chk(highs == 5, "R5 ready high for 5 cycles", highs, 5);
    @(negedge clk);
    chk(!u_ready_n && !l_valid, "R5 ready back, nothing committed", {u_ready_n, l_valid}, 2'b00);
    push(32'hC000_0000, 0); exp_q.push_back({1'b0, 32'hC000_0000});
    push(32'hC000_0001, 1); exp_q.push_back({1'b1, 32'hC000_0001});
    idle();
    drain("R5 only new frame survives");
  endtask

  task automatic t_abort_idle();
    push(32'hD000_0000, 0); exp_q.push_back({1'b0, 32'hD000_0000});
    push(32'hD000_0001, 1); exp_q.push_back({1'b1, 32'hD000_0001});
    idle();
    @(negedge clk); u_abort_n = 1'b0;
    @(negedge clk); u_abort_n = 1'b1;
    chk(!u_ready_n, "R6 abort outside frame ignored", u_ready_n, 0);
    drain("R6 frame intact");
  endtask

  task automatic t_cancel_idle();
    @(negedge clk); l_cancel = 1'b1;
    @(negedge clk); l_cancel = 1'b0;
    chk(!u_cancel_n, "R7 cancel pulse low", u_cancel_n, 0);
    @(negedge clk);
    chk(u_cancel_n, "R7 cancel pulse one cycle", u_cancel_n, 1);
  endtask

  task automatic t_cancel_mid();
    for (int j = 0; j < 4; j++) push(32'hE000_0000 + j, j == 3);
    push(32'hF000_0000, 0); exp_q.push_back({1'b0, 32'hF000_0000});
    push(32'hF000_0001, 1); exp_q.push_back({1'b1, 32'hF000_0001});
    idle();
    @(negedge clk); l_ready = 1'b1;
    chk(l_data == 32'hE000_0000, "R2 first word of frame", l_data, 32'hE000_0000);
    @(negedge clk); l_ready = 1'b0; l_cancel = 1'b1;
    chk(l_data == 32'hE000_0001, "R2 second word of frame", l_data, 32'hE000_0001);
    @(negedge clk); l_cancel = 1'b0;
    chk(!u_cancel_n && !l_valid, "R8 cancel notice, output muted", {u_cancel_n, l_valid}, 2'b00);
    drain("R8 rest of frame dropped");
  endtask

  task automatic t_overlap();
    @(negedge clk); l_cancel = 1'b1; l_done = 1'b1; l_code = 2'b01;
    @(negedge clk); l_cancel = 1'b0; l_done = 1'b0; l_code = 2'b00;
    chk(!u_cancel_n && st_valid && st_word == 32'h0100_00EF, "R10 cancel with status",
        {u_cancel_n, st_valid, st_word}, {2'b01, 32'h0100_00EF});
  endtask

  initial begin
    t_reset();
    t_basic();
    t_status();
    t_fill();
    t_abort();
    t_abort_idle();
    t_cancel_idle();
    t_cancel_mid();
    t_overlap();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule